// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller (Cascaded Pair)

This block collects interrupt requests from peripheral lines, picks the most urgent eligible one under a fixed priority order, and signals the processor through a single interrupt request output. When the processor answers with a one-cycle acknowledge pulse, the block returns an 8-bit vector on its vector output. The vector is a software-chosen 5-bit base joined with the 3-bit number of the winning line. The processor uses this vector to select a handler.

The top level holds two identical controller cores. The secondary core's request output drives input 2 of the primary core, so the pair serves 15 external lines. Each core tracks which of its lines are in service. A newly arriving request of higher priority can interrupt a handler that is running. Requests of equal or lower priority wait until software issues an end-of-service strobe. When the primary's winner is the cascade input, the acknowledge is passed to the secondary core, and the vector comes from the secondary.

Top module: `irq_vec_pair`

## Requirements
- R1: After reset, `intr_o` and `vec_vld_o` are 0, and no line is pending or in service.
- R2: A rising edge on a line, sampled at a clock edge, latches a request. `intr_o` is high in the cycle after that edge if the line is eligible. A line held high does not request again.
- R3: An `inta_i` pulse in cycle t makes `vec_vld_o` high in cycle t+1 only. In that cycle `vec_o` = {base[4:0], line[2:0]}, with the line number in bits 2:0.
- R4: Priority is fixed, with line 0 highest and line 7 lowest. Requests that arrive together are granted one per acknowledge, in that order, as each handler ends.
- R5: On acknowledge, the winner's in-service bit is set and its request latch is cleared. `intr_o` falls if no other request is eligible.
- R6: A latched request is held back while any in-service bit of equal or higher priority (equal or lower index) is set.
- R7: A request of higher priority than every in-service line raises `intr_o` and is granted on acknowledge, nesting over the running handler.
- R8: `eos_i` (primary) and `slv_eos_i` (secondary) each clear the highest-priority in-service bit of their own core. When a strobe falls in the same cycle as an acknowledge, it acts on the in-service set from before that grant.
- R9: External lines 0..7 feed the primary core and lines 8..15 feed secondary lines 0..7. Primary input 2 is driven by the secondary's request, so `line_i[2]` has no effect.
- R10: When the primary winner at acknowledge is input 2, the secondary is acknowledged too, and `vec_o` = {`slv_base_i`, secondary line}.
- R11: An acknowledge with no eligible primary request returns {`mst_base_i`, 3'd7} and changes no pending or in-service state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | 16 | Request lines; 7:0 primary (bit 2 unused), 15:8 secondary |
| mst_base_i | input | 5 | Vector base of the primary core |
| slv_base_i | input | 5 | Vector base of the secondary core |
| inta_i | input | 1 | Acknowledge pulse from the processor |
| eos_i | input | 1 | End-of-service strobe, primary core |
| slv_eos_i | input | 1 | End-of-service strobe, secondary core |
| intr_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector returned after acknowledge |
| vec_vld_o | output | 1 | Vector valid, one cycle after acknowledge |

## Verification
The acknowledge and the end-of-service strobe can arrive in the same cycle. The grant must then be decided against the old in-service set, and the strobe must retire the old top handler rather than the new one. The bench sets up this case as follows: line 5 is in service and line 3 is pending, and it then raises both strobes together. It then pulses line 4 and observes `intr_o`. If `intr_o` stays low, line 3 is still in service and line 5 has been retired. If it rises, the wrong bit was cleared.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NUM_LINES = 8;
  localparam int unsigned BASE_W    = 5;
  localparam int unsigned CASC_LINE = 2;

  typedef enum logic {
    SRC_MST = 1'b0,
    SRC_SLV = 1'b1
  } vec_src_e;
endpackage

// File: rtl/irq_prio.sv
// Lowest set index wins (index 0 is most urgent)
module irq_prio #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned IDX_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] vec_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
    any_o = |vec_i;
  end
endmodule

// File: rtl/irq_core.sv
module irq_core #(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned BASE_W    = 5,
  localparam int unsigned IDX_W = $clog2(NUM_LINES),
  localparam int unsigned VEC_W = BASE_W + IDX_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] line_i,
  input  logic [BASE_W-1:0]    base_i,
  input  logic                 inta_i,
  input  logic                 eos_i,
  output logic                 intr_o,
  output logic [IDX_W-1:0]     win_o,
  output logic [VEC_W-1:0]     vec_o
);
  localparam logic [NUM_LINES-1:0] ONE = NUM_LINES'(1);

  logic [NUM_LINES-1:0] line_q, req_q, isr_q;
  logic [NUM_LINES-1:0] rise, blk, pend;
  logic [NUM_LINES-1:0] grant_mask, retire_mask;
  logic [IDX_W-1:0]     win, top_isr;
  logic                 any_pend, any_isr, ack_ok;
  logic [VEC_W-1:0]     vec_q;

  assign rise = line_i & ~line_q;

  // blk[i]: some line at index <= i is in service
  assign blk[0] = isr_q[0];
  for (genvar g = 1; g < NUM_LINES; g++) begin : g_blk
    assign blk[g] = blk[g-1] | isr_q[g];
  end

  assign pend = req_q & ~blk;

  irq_prio #(.WIDTH(NUM_LINES)) u_pend_prio (
    .vec_i(pend), .idx_o(win), .any_o(any_pend)
  );
  irq_prio #(.WIDTH(NUM_LINES)) u_isr_prio (
    .vec_i(isr_q), .idx_o(top_isr), .any_o(any_isr)
  );

  assign ack_ok      = inta_i & any_pend;
  assign grant_mask  = ack_ok ? (ONE << win) : '0;
  assign retire_mask = (eos_i & any_isr) ? (ONE << top_isr) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      req_q  <= '0;
      isr_q  <= '0;
      vec_q  <= '0;
    end else begin
      line_q <= line_i;
      req_q  <= (req_q & ~grant_mask) | rise;
      isr_q  <= (isr_q & ~retire_mask) | grant_mask;
      if (inta_i) vec_q <= {base_i, ack_ok ? win : IDX_W'(NUM_LINES - 1)};
    end
  end

  assign intr_o = any_pend;
  assign win_o  = win;
  assign vec_o  = vec_q;

  p_ack_sets_isr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_ok |=> isr_q[$past(win)]);

  p_ack_clears_req_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_ok |=> (!req_q[$past(win)] || $past(rise[win])));

  p_no_equal_or_lower_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_ok && any_isr) |-> (win < top_isr));

  p_eos_retires_one_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eos_i && any_isr && !inta_i) |=>
      ($countones(isr_q) == $countones($past(isr_q)) - 1));

  p_spurious_no_change_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && !any_pend && !eos_i) |=> (isr_q == $past(isr_q)));
endmodule

// File: rtl/irq_vec_pair.sv
module irq_vec_pair
  import irq_pkg::*;
#(
  parameter int unsigned N_LINES = NUM_LINES,
  parameter int unsigned B_W     = BASE_W,
  parameter int unsigned CASC    = CASC_LINE,
  localparam int unsigned IDX_W  = $clog2(N_LINES),
  localparam int unsigned VEC_W  = B_W + IDX_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [2*N_LINES-1:0]   line_i,
  input  logic [B_W-1:0]         mst_base_i,
  input  logic [B_W-1:0]         slv_base_i,
  input  logic                   inta_i,
  input  logic                   eos_i,
  input  logic                   slv_eos_i,
  output logic                   intr_o,
  output logic [VEC_W-1:0]       vec_o,
  output logic                   vec_vld_o
);
  logic [N_LINES-1:0] mst_lines;
  logic               mst_intr, slv_intr, slv_ack;
  logic [IDX_W-1:0]   mst_win, slv_win;
  logic [VEC_W-1:0]   mst_vec, slv_vec;
  logic               vld_q;
  vec_src_e           src_q;

  for (genvar g = 0; g < N_LINES; g++) begin : g_mst_in
    if (g == CASC) begin : g_link
      assign mst_lines[g] = slv_intr;
    end else begin : g_ext
      assign mst_lines[g] = line_i[g];
    end
  end

  assign slv_ack = inta_i & mst_intr & (mst_win == IDX_W'(CASC));

  irq_core #(.NUM_LINES(N_LINES), .BASE_W(B_W)) u_mst (
    .clk_i, .rst_ni, .line_i(mst_lines), .base_i(mst_base_i),
    .inta_i, .eos_i, .intr_o(mst_intr), .win_o(mst_win), .vec_o(mst_vec)
  );

  irq_core #(.NUM_LINES(N_LINES), .BASE_W(B_W)) u_slv (
    .clk_i, .rst_ni, .line_i(line_i[2*N_LINES-1:N_LINES]), .base_i(slv_base_i),
    .inta_i(slv_ack), .eos_i(slv_eos_i), .intr_o(slv_intr), .win_o(slv_win),
    .vec_o(slv_vec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      src_q <= SRC_MST;
    end else begin
      vld_q <= inta_i;
      if (inta_i) src_q <= slv_ack ? SRC_SLV : SRC_MST;
    end
  end

  assign intr_o    = mst_intr;
  assign vec_vld_o = vld_q;
  assign vec_o     = (src_q == SRC_SLV) ? slv_vec : mst_vec;

  p_vld_follows_ack_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (vec_vld_o == $past(inta_i)));

  p_casc_index_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slv_ack |=> (vec_o[IDX_W-1:0] == $past(slv_win)));
endmodule

// File: tb/test_irq_vec_pair.sv
`timescale 1ns/1ps
module test_irq_vec_pair;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] line = '0;
  logic [4:0]  mst_base = 5'h08;
  logic [4:0]  slv_base = 5'h09;
  logic        inta = 1'b0, eos = 1'b0, slv_eos = 1'b0;
  logic        intr;
  logic [7:0]  vec;
  logic        vld;
  int          n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  irq_vec_pair i_irq_vec_pair (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .mst_base_i(mst_base),
    .slv_base_i(slv_base), .inta_i(inta), .eos_i(eos), .slv_eos_i(slv_eos),
    .intr_o(intr), .vec_o(vec), .vec_vld_o(vld)
  );

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse(logic [15:0] m);
    line = line | m; tick();
    line = line & ~m; tick(); tick();
  endtask

  task automatic ack(string req, logic [7:0] exp);
    inta = 1'b1; tick(); inta = 1'b0;
    chk({req, " vld"}, 32'(vld), 1);
    chk({req, " vec"}, 32'(vec), 32'(exp));
    tick();
    chk("R3 vld single cycle", 32'(vld), 0);
  endtask

  task automatic end_svc(); eos = 1'b1; tick(); eos = 1'b0; endtask
  task automatic end_slv(); slv_eos = 1'b1; tick(); slv_eos = 1'b0; endtask

  task automatic t_reset();
    chk("R1 intr", 32'(intr), 0);
    chk("R1 vld", 32'(vld), 0);
  endtask

  task automatic t_single();
    line[5] = 1'b1; tick();
    chk("R2 intr after edge", 32'(intr), 1);
    tick(); tick();
    ack("R3 line5", 8'h45);
    chk("R5 intr drops", 32'(intr), 0);
    line[5] = 1'b0; tick(); tick();
    chk("R2 held level no rerequest", 32'(intr), 0);
    end_svc();
  endtask

  task automatic t_order();
    pulse(16'h004A);
    ack("R4 first", 8'h41);
    chk("R6 lower held", 32'(intr), 0);
    end_svc();
    chk("R4 next pending", 32'(intr), 1);
    ack("R4 second", 8'h43);
    end_svc();
    ack("R4 third", 8'h46);
    end_svc();
    chk("R4 all done", 32'(intr), 0);
  endtask

  task automatic t_nest();
    pulse(16'h0040);
    ack("R3 line6", 8'h46);
    pulse(16'h0010);
    chk("R7 higher raises", 32'(intr), 1);
    ack("R7 nested", 8'h44);
    pulse(16'h0080);
    chk("R6 lower blocked", 32'(intr), 0);
    end_svc();
    chk("R8 retire top only", 32'(intr), 0);
    end_svc();
    chk("R8 second retire", 32'(intr), 1);
    ack("R6 released", 8'h47);
    end_svc();
  endtask

  task automatic t_cascade();
    pulse(16'h0800);
    tick();
    chk("R9 slave reaches intr", 32'(intr), 1);
    ack("R10 slave vec", 8'h4B);
    chk("R10 intr drops", 32'(intr), 0);
    pulse(16'h0002);
    chk("R7 master over cascade", 32'(intr), 1);
    ack("R7 master line1", 8'h41);
    end_svc(); end_svc(); end_slv();
    pulse(16'h2000);
    tick();
    ack("R10 slave line5", 8'h4D);
    end_svc(); end_slv();
    chk("R8 pair idle", 32'(intr), 0);
  endtask

  task automatic t_ignored();
    pulse(16'h0004);
    tick();
    chk("R9 line 2 ignored", 32'(intr), 0);
    ack("R11 spurious", 8'h47);
    chk("R11 no intr", 32'(intr), 0);
    pulse(16'h0020);
    ack("R11 state intact", 8'h45);
    end_svc();
  endtask

  task automatic t_same_cycle();
    pulse(16'h0020);
    ack("R8 setup", 8'h45);
    pulse(16'h0008);
    chk("R7 line3 over 5", 32'(intr), 1);
    inta = 1'b1; eos = 1'b1; tick(); inta = 1'b0; eos = 1'b0;
    chk("R8 combined vec", 32'(vec), 32'h43);
    tick();
    pulse(16'h0010);
    chk("R8 old handler retired", 32'(intr), 0);
    end_svc();
    chk("R8 new handler retired", 32'(intr), 1);
    ack("R8 line4", 8'h44);
    end_svc();
  endtask

  initial begin
    #1000000;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    tick(); tick();
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_single();
    t_order();
    t_nest();
    t_cascade();
    t_ignored();
    t_same_cycle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule